// File: doc/BRIEF.md
# BCD calendar timekeeping core

This block keeps wall-clock time and calendar date in packed BCD. A 32768 Hz enable pulse, `osc_en`, is divided down to a one-second tick. The tick drives a chain of counters: seconds, minutes, 24-hour hours, a day-of-week counter, day of month, month, two-digit year, and a century bit. Day-of-month rollover follows the month length, and February has 29 days when the two-digit year is a multiple of four. A stop bit freezes the whole chain. When the century bit is enabled, it flips each time the year wraps from 99 to 00.

Software reaches ten byte-wide registers through a plain register port. An access window is marked by `xfer_active`. When the window opens, a transfer buffer takes a snapshot of the running counters, so every read inside that window sees one consistent instant. Writes inside the window change only the buffer. When a window that contained at least one write closes, the whole buffer is loaded into the counters in one cycle, and the sub-second divider restarts from zero. The port has no back-pressure: every strobe is taken in the cycle it is presented, and read data appears on the following cycle. Addresses 7 to 9 are spare bytes that are stored as written and carried through the same buffer.

Top module: `rtc_calendar_core`

## Requirements
- R1: While the stop bit is clear, `second_tick` pulses on every DIV_RATIO-th cycle that has `osc_en` high, and never on a cycle without `osc_en`. Each pulse advances the seconds counter by one.
- R2: The fields are packed BCD with tens above units. Seconds (address 0, bits 6:0) wrap from 59 to 00 and carry into minutes. Minutes (address 1, bits 6:0) wrap from 59 to 00 and carry into hours. Hours (address 2, bits 5:0) wrap from 23 to 00 and carry into the day counters. Year (address 6) runs 00 to 99.
- R3: While the stop bit (address 0, bit 7) is set, no tick occurs and every time and date counter holds its value.
- R4: Address 2 bit 7 enables the century bit, which sits at address 2 bit 6. When the year wraps from 99 to 00, the century bit flips if it is enabled and holds if it is not.
- R5: The following bits always read as 0, whatever was written to them: address 1 bit 7, address 3 bits 7:6 and bit 3, address 4 bits 7:6, and address 5 bits 7:5. Addresses 10 to 15 read 0, and writes to them have no effect.
- R6: Opening the window (`xfer_active` rising) captures all counters into the buffer. Reads in that window return that snapshot, even while the counters advance. Read data is valid on the cycle after `reg_rd`.
- R7: Writes change only the buffer. The counters load from the buffer on the cycle the window closes, and only if the window held a write. That load also clears the divider, so the next tick follows DIV_RATIO enables later. Write strobes while the window is closed are ignored.
- R8: Day of month (address 4, bits 5:0) wraps to 01 after 30 in April, June, September and November. It wraps after 31 in the other long months. In February it wraps after 29 when the year is a multiple of four, and after 28 otherwise. Month (address 5, bits 4:0) wraps from 12 to 01 and carries into the year.
- R9: Day of week (address 3, bits 2:0) counts 1 to 7 and goes from 7 back to 1 at each midnight, regardless of the date.
- R10: Address 3 bits 5:4 are test bits. They are stored and read back, and they have no effect on counting.
- R11: Addresses 7, 8 and 9 hold plain bytes. They are stored as written and follow the same snapshot and commit rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-cycle enable at the 32768 Hz oscillator rate |
| xfer_active | input | 1 | High for the duration of a register access window |
| reg_addr | input | 4 | Register address (0 to 9 valid) |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, honoured only inside a window |
| reg_rd | input | 1 | Read strobe, honoured only inside a window |
| reg_rdata | output | 8 | Read data, registered, valid the cycle after `reg_rd` |
| second_tick | output | 1 | One-cycle pulse marking each counted second |

## Verification
The bound checker watches several rules on every cycle. It checks that the chain stays frozen under the stop bit, that each tick moves the seconds, and that the century bit flips exactly on an enabled year wrap and holds otherwise. It also checks that the buffer is still between writes, that a commit only follows a window closing, that masked bits and out-of-range addresses read zero, and that day of week stays within 1 to 7. Other behaviours can only be shown by the bench scenarios: carries through a full midnight, month and year boundary, the February leap rule, the exact divider phase after a commit, the effect of a gated oscillator enable, and whether a snapshot taken at a known instant matches the time a reference model has counted.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int NREG   = 10;
  localparam int REG_AW = 4;
  localparam int NAUX   = NREG - 7;

  typedef logic [7:0] bcd8_t;

  // Writable-bit mask per register; masked bits read as zero.
  function automatic logic [7:0] reg_mask(input int idx);
    case (idx)
      1:       return 8'h7F;
      3:       return 8'h37;
      4:       return 8'h3F;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic bcd8_t bcd_inc(input bcd8_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input bcd8_t yr);
    logic [7:0] bin;
    bin = 8'(yr[7:4]) * 8'd10 + 8'(yr[3:0]);
    return bin[1:0] == 2'b00;
  endfunction

  // Last day of the month, in BCD.
  function automatic bcd8_t month_last(input bcd8_t mon, input bcd8_t yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int DIV_RATIO = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic hold,
  input  logic clear,
  output logic tick
);
  localparam int CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (hold || clear)   cnt <= '0;
    else if (osc_en)          cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
  end

  assign tick = osc_en && !hold && !clear && (cnt == LAST);
endmodule

// File: rtl/rtc_bcd_count.sv
`timescale 1ns/1ps
module rtc_bcd_count
  import rtc_pkg::*;
#(
  parameter logic [7:0] FIRST = 8'h00
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  bcd8_t last,
  input  logic  load,
  input  bcd8_t load_val,
  output bcd8_t value,
  output logic  wrap
);
  logic at_end;
  assign at_end = (value >= last);
  assign wrap   = step && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= FIRST;
    else if (load) value <= load_val;
    else if (step) value <= at_end ? FIRST : bcd_inc(value);
  end
endmodule

// File: rtl/rtc_xfer_buffer.sv
`timescale 1ns/1ps
module rtc_xfer_buffer
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_active,
  input  logic [NREG*8-1:0] live_img,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [7:0]        reg_rdata,
  output logic              commit,
  output logic [NREG*8-1:0] buf_img,
  output logic              xfer_q
);
  logic [7:0] buf_q [NREG];
  logic       dirty_q;
  logic       start;
  logic       addr_ok;
  logic       wr_hit;

  assign start   = xfer_active && !xfer_q;
  assign addr_ok = (reg_addr < REG_AW'(NREG));
  assign wr_hit  = xfer_active && reg_wr && addr_ok;
  assign commit  = xfer_q && !xfer_active && dirty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xfer_q <= 1'b0;
    else        xfer_q <= xfer_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            dirty_q <= 1'b0;
    else if (!xfer_active) dirty_q <= 1'b0;
    else if (start)        dirty_q <= wr_hit;
    else if (wr_hit)       dirty_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) buf_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (start) buf_q[i] <= live_img[i*8 +: 8];
        if (wr_hit && reg_addr == REG_AW'(i)) buf_q[i] <= reg_wdata & reg_mask(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd && xfer_active) begin
      if (!addr_ok)   reg_rdata <= '0;
      else if (start) reg_rdata <= live_img[reg_addr*8 +: 8];
      else            reg_rdata <= buf_q[reg_addr];
    end
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) buf_img[i*8 +: 8] = buf_q[i];
  end
endmodule

// File: rtl/rtc_calendar_core.sv
`timescale 1ns/1ps
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int DIV_RATIO = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic              xfer_active,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [7:0]        reg_rdata,
  output logic              second_tick
);
  bcd8_t sec_v, min_v, hr_v, dow_v, date_v, mon_v, yr_v;
  logic  wrap_sec, wrap_min, wrap_hr, wrap_dow, wrap_date, wrap_mon, wrap_yr;
  logic  ctl_stop, ctl_cen_en, ctl_cen;
  logic [1:0] ctl_test;
  logic [7:0] aux_q [NAUX];
  logic [NREG*8-1:0] live_img;
  logic [NREG*8-1:0] buf_img;
  logic  commit;
  logic  xfer_q;

  rtc_prescaler #(.DIV_RATIO(DIV_RATIO)) u_pre (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en),
    .hold(ctl_stop), .clear(commit), .tick(second_tick)
  );

  rtc_xfer_buffer u_buf (
    .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active), .live_img(live_img),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .commit(commit), .buf_img(buf_img), .xfer_q(xfer_q)
  );

  // Counter chain: each stage steps on the wrap of the one below.
  rtc_bcd_count #(.FIRST(8'h00)) u_sec (
    .clk(clk), .rst_n(rst_n), .step(second_tick), .last(8'h59),
    .load(commit), .load_val({1'b0, buf_img[6:0]}), .value(sec_v), .wrap(wrap_sec)
  );
  rtc_bcd_count #(.FIRST(8'h00)) u_min (
    .clk(clk), .rst_n(rst_n), .step(wrap_sec), .last(8'h59),
    .load(commit), .load_val(buf_img[15:8]), .value(min_v), .wrap(wrap_min)
  );
  rtc_bcd_count #(.FIRST(8'h00)) u_hr (
    .clk(clk), .rst_n(rst_n), .step(wrap_min), .last(8'h23),
    .load(commit), .load_val(buf_img[23:16] & 8'h3F), .value(hr_v), .wrap(wrap_hr)
  );
  rtc_bcd_count #(.FIRST(8'h01)) u_dow (
    .clk(clk), .rst_n(rst_n), .step(wrap_hr), .last(8'h07),
    .load(commit), .load_val(buf_img[31:24] & 8'h07), .value(dow_v), .wrap(wrap_dow)
  );
  rtc_bcd_count #(.FIRST(8'h01)) u_date (
    .clk(clk), .rst_n(rst_n), .step(wrap_hr), .last(month_last(mon_v, yr_v)),
    .load(commit), .load_val(buf_img[39:32]), .value(date_v), .wrap(wrap_date)
  );
  rtc_bcd_count #(.FIRST(8'h01)) u_mon (
    .clk(clk), .rst_n(rst_n), .step(wrap_date), .last(8'h12),
    .load(commit), .load_val(buf_img[47:40]), .value(mon_v), .wrap(wrap_mon)
  );
  rtc_bcd_count #(.FIRST(8'h00)) u_yr (
    .clk(clk), .rst_n(rst_n), .step(wrap_mon), .last(8'h99),
    .load(commit), .load_val(buf_img[55:48]), .value(yr_v), .wrap(wrap_yr)
  );

  // Control flags held beside the counters.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_stop   <= 1'b0;
      ctl_cen_en <= 1'b0;
      ctl_cen    <= 1'b0;
      ctl_test   <= 2'b00;
    end else if (commit) begin
      ctl_stop   <= buf_img[7];
      ctl_cen_en <= buf_img[23];
      ctl_cen    <= buf_img[22];
      ctl_test   <= buf_img[29:28];
    end else if (wrap_yr && ctl_cen_en) begin
      ctl_cen    <= !ctl_cen;
    end
  end

  // Spare bytes at the top of the map.
  for (genvar g = 0; g < NAUX; g++) begin : g_aux
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      aux_q[g] <= '0;
      else if (commit) aux_q[g] <= buf_img[(7+g)*8 +: 8];
    end
    assign live_img[(7+g)*8 +: 8] = aux_q[g];
  end

  assign live_img[7:0]   = {ctl_stop, sec_v[6:0]};
  assign live_img[15:8]  = {1'b0, min_v[6:0]};
  assign live_img[23:16] = {ctl_cen_en, ctl_cen, hr_v[5:0]};
  assign live_img[31:24] = {2'b00, ctl_test, 1'b0, dow_v[2:0]};
  assign live_img[39:32] = {2'b00, date_v[5:0]};
  assign live_img[47:40] = {3'b000, mon_v[4:0]};
  assign live_img[55:48] = yr_v;
endmodule

// File: rtl/rtc_calendar_checker.sv
`timescale 1ns/1ps
module rtc_calendar_checker
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_active,
  input logic              xfer_q,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [7:0]        reg_rdata,
  input logic              second_tick,
  input logic              commit,
  input logic              wrap_yr,
  input logic              ctl_stop,
  input logic              ctl_cen_en,
  input logic              ctl_cen,
  input logic [7:0]        sec_v,
  input logic [7:0]        min_v,
  input logic [7:0]        hr_v,
  input logic [7:0]        dow_v,
  input logic [7:0]        date_v,
  input logic [7:0]        mon_v,
  input logic [7:0]        yr_v,
  input logic [NREG*8-1:0] buf_img
);
  assert_tick_moves_sec_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (second_tick && !commit) |=> (sec_v != $past(sec_v)));

  assert_stop_freezes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_stop && !commit) |=> ($stable(sec_v) && $stable(min_v) && $stable(hr_v) &&
                               $stable(dow_v) && $stable(date_v) && $stable(mon_v) &&
                               $stable(yr_v)));

  assert_stop_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_stop |-> !second_tick);

  assert_century_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_yr && ctl_cen_en && !commit) |=> (ctl_cen != $past(ctl_cen)));

  assert_century_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wrap_yr && ctl_cen_en) && !commit) |=> $stable(ctl_cen));

  assert_masked_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && xfer_active && (reg_addr == 4'd1 || reg_addr == 4'd4 || reg_addr == 4'd5))
      |=> (reg_rdata[7] == 1'b0));

  assert_high_addr_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && xfer_active && reg_addr >= REG_AW'(NREG)) |=> (reg_rdata == 8'h00));

  assert_buffer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && xfer_q && !reg_wr) |=> $stable(buf_img));

  assert_commit_on_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (!xfer_active && $past(xfer_active)));

  assert_dow_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dow_v >= 8'h01 && dow_v <= 8'h07));
endmodule

bind rtc_calendar_core rtc_calendar_checker u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active), .xfer_q(xfer_q),
  .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .second_tick(second_tick), .commit(commit), .wrap_yr(wrap_yr),
  .ctl_stop(ctl_stop), .ctl_cen_en(ctl_cen_en), .ctl_cen(ctl_cen),
  .sec_v(sec_v), .min_v(min_v), .hr_v(hr_v), .dow_v(dow_v), .date_v(date_v),
  .mon_v(mon_v), .yr_v(yr_v), .buf_img(buf_img)
);

// File: tb/rtc_calendar_core_test.sv
`timescale 1ns/1ps
module rtc_calendar_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic       xfer_active = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       second_tick;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_calendar_core #(.DIV_RATIO(4)) uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .xfer_active(xfer_active),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .second_tick(second_tick)
  );

  // Reference model state.
  int e_sec = 0, e_min = 0, e_hr = 0, e_dow = 1, e_date = 1, e_mon = 1, e_yr = 0;
  int e_cen = 0, e_cen_en = 0, e_stop = 0, e_test = 0;
  int e_aux [3] = '{0, 0, 0};

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int days_in(input int m, input int y);
    case (m)
      2:             return (y % 4 == 0) ? 29 : 28;
      4, 6, 9, 11:   return 30;
      default:       return 31;
    endcase
  endfunction

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic logic [7:0] exp_byte(input int i);
    case (i)
      0: return (e_stop != 0 ? 8'h80 : 8'h00) | bcd(e_sec);
      1: return bcd(e_min);
      2: return (e_cen_en != 0 ? 8'h80 : 8'h00) | (e_cen != 0 ? 8'h40 : 8'h00) | bcd(e_hr);
      3: return 8'(e_test * 16 + e_dow);
      4: return bcd(e_date);
      5: return bcd(e_mon);
      6: return bcd(e_yr);
      default: return 8'(e_aux[i-7]);
    endcase
  endfunction

  function automatic string req_of(input int i);
    case (i)
      0, 1, 6: return "R2";
      2:       return "R4";
      3:       return "R9/R10";
      4, 5:    return "R8";
      default: return "R11";
    endcase
  endfunction

  function automatic void model_tick();
    if (e_stop != 0) return;
    e_sec++;  if (e_sec < 60) return;
    e_sec = 0; e_min++; if (e_min < 60) return;
    e_min = 0; e_hr++;  if (e_hr < 24) return;
    e_hr = 0;
    e_dow = (e_dow == 7) ? 1 : e_dow + 1;
    e_date++; if (e_date <= days_in(e_mon, e_yr)) return;
    e_date = 1; e_mon++; if (e_mon <= 12) return;
    e_mon = 1; e_yr++; if (e_yr < 100) return;
    e_yr = 0;
    if (e_cen_en != 0) e_cen = 1 - e_cen;
  endfunction

  // All tasks are entered and left at a falling edge.
  task automatic win_open();
    xfer_active = 1'b1;
    @(negedge clk);
  endtask

  task automatic win_close();
    xfer_active = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_byte(input int a, input logic [7:0] d);
    reg_addr = 4'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_byte(input int a, output logic [7:0] d);
    reg_addr = 4'(a); reg_rd = 1'b1;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_model();
    win_open();
    for (int i = 0; i < 10; i++) wr_byte(i, exp_byte(i));
    win_close();
  endtask

  task automatic read_check(input string tag);
    logic [7:0] got [10];
    logic [7:0] again;
    win_open();
    for (int i = 0; i < 10; i++) rd_byte(i, got[i]);
    rd_byte(0, again);
    win_close();
    for (int i = 0; i < 10; i++)
      check($sformatf("%s %s byte%0d", tag, req_of(i), i), got[i], exp_byte(i));
    check($sformatf("%s R6 snapshot stable", tag), again, got[0]);
  endtask

  task automatic set_time(input int yr, input int mon, input int date, input int dow,
                          input int hr, input int mn, input int sc);
    e_yr = yr; e_mon = mon; e_date = date; e_dow = dow;
    e_hr = hr; e_min = mn; e_sec = sc;
  endtask

  // Write the model, let n seconds pass, read back.
  task automatic run_secs(input string tag, input int n);
    write_model();
    idle(4 * n + 1);
    for (int k = 0; k < n; k++) model_tick();
    read_check(tag);
  endtask

  initial begin
    logic [7:0] d;
    int ticks;
    void'($urandom(32'd20240611));

    idle(5);
    rst_n = 1'b1;
    idle(2);

    // Reset state.
    read_check("reset R6");

    osc_en = 1'b1;

    // Masking and test bits read back from the buffer within one window.
    win_open();
    wr_byte(1, 8'hFF); rd_byte(1, d); check("R5 minutes top bit", d, 8'h7F);
    wr_byte(4, 8'hFF); rd_byte(4, d); check("R5 date top bits", d, 8'h3F);
    wr_byte(5, 8'hFF); rd_byte(5, d); check("R5 month top bits", d, 8'h1F);
    wr_byte(3, 8'hFF); rd_byte(3, d); check("R5/R10 dow register bits", d, 8'h37);
    wr_byte(12, 8'hA5); rd_byte(12, d); check("R5 address 12 reads zero", d, 8'h00);
    win_close();

    // Tick spacing right after a commit.
    e_stop = 0; e_cen_en = 0; e_cen = 0; e_test = 0;
    set_time(23, 6, 15, 3, 10, 20, 30);
    write_model();
    for (int k = 0; k < 12; k++) begin
      check($sformatf("R1/R7 tick phase k=%0d", k), second_tick, ((k % 4) == 3) ? 1'b1 : 1'b0);
      @(negedge clk);
    end
    for (int k = 0; k < 3; k++) model_tick();
    read_check("R1 after three ticks");

    // Gated oscillator enable: no ticks.
    write_model();
    osc_en = 1'b0;
    ticks = 0;
    for (int k = 0; k < 30; k++) begin
      if (second_tick) ticks++;
      @(negedge clk);
    end
    osc_en = 1'b1;
    check("R1 no tick without osc_en", ticks, 0);
    read_check("R1 gated");

    // Stop bit.
    e_stop = 1;
    set_time(50, 7, 4, 5, 12, 0, 0);
    write_model();
    ticks = 0;
    for (int k = 0; k < 41; k++) begin
      if (second_tick) ticks++;
      @(negedge clk);
    end
    check("R3 no tick while stopped", ticks, 0);
    read_check("R3 frozen");

    // Write strobe outside a window is ignored.
    reg_addr = 4'd6; reg_wdata = 8'h55; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    idle(2);
    read_check("R7 closed-window write");
    e_stop = 0;

    // Calendar corners.
    set_time(23, 2, 28, 7, 23, 59, 57);
    run_secs("R2/R8/R9 non-leap Feb", 4);
    set_time(24, 2, 28, 2, 23, 59, 59);
    run_secs("R8 leap Feb 28", 1);
    set_time(24, 2, 29, 3, 23, 59, 59);
    run_secs("R8 leap Feb 29", 1);
    set_time(31, 4, 30, 6, 23, 59, 58);
    run_secs("R8 April end", 3);
    e_cen_en = 1; e_cen = 0;
    set_time(99, 12, 31, 4, 23, 59, 59);
    run_secs("R4 century enabled", 2);
    e_cen_en = 0; e_cen = 1;
    set_time(99, 12, 31, 4, 23, 59, 59);
    run_secs("R4 century disabled", 2);
    e_test = 3;
    set_time(11, 1, 31, 7, 23, 59, 59);
    run_secs("R9/R10 test bits set", 2);
    e_test = 0;

    // Randomised times biased toward rollover points.
    for (int it = 0; it < 40; it++) begin
      int n;
      e_stop   = 0;
      e_yr     = ($urandom % 4 == 0) ? 99 : int'($urandom % 100);
      e_mon    = ($urandom % 4 == 0) ? 12 : 1 + int'($urandom % 12);
      e_date   = ($urandom % 2 == 0) ? days_in(e_mon, e_yr)
                                     : 1 + int'($urandom % days_in(e_mon, e_yr));
      e_dow    = 1 + int'($urandom % 7);
      e_hr     = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
      e_min    = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
      e_sec    = ($urandom % 2 == 0) ? 50 + int'($urandom % 10) : int'($urandom % 60);
      e_cen_en = int'($urandom % 2);
      e_cen    = int'($urandom % 2);
      e_test   = int'($urandom % 4);
      for (int a = 0; a < 3; a++) e_aux[a] = int'($urandom % 256);
      n = int'($urandom % 40);
      run_secs($sformatf("random %0d", it), n);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule